// File: doc/BRIEF.md
# Byte-Wide One-Time-Programmable Memory Burn Sequencer

This block writes a full memory image into an erasable or one-time-programmable byte-wide memory of 2^ADDR_W locations (32,768 bytes at the default setting). It fetches the desired byte for each location from a source read port. It reads the target location once before programming. It then applies fixed-width program pulses, with a read-back compare after every pulse, until the byte matches or a pulse limit is reached. The block works through the locations in ascending order.

Once the last location has been programmed, the block lowers the program-voltage flag and raises a verify-level select. It then reads back the whole array a second time against the source. It stops at the first problem. An error code tells the cause, and the failing location is held until the next start. Pulse width is set in clock cycles, so a 100 MHz clock with PULSE_CYC = 10000 gives a 100 microsecond pulse.

The source port has a read latency of one cycle: `src_data` must hold the byte for the `src_addr` value seen on the previous clock edge. The target strobes are active low. The target drives `tgt_din` while both strobes are low.

Top module: `otp_burn_seq`

## Requirements
- R1: While `rst` is high and after it, with no start, the outputs are idle: `tgt_ce_n`=1, `tgt_oe_n`=1, `tgt_dout_en`=0, `tgt_vpp_en`=0, `tgt_vfy_sel`=0, `busy`=0, `done`=0, `err_code`=0.
- R2: A program pulse holds `tgt_ce_n` low with `tgt_oe_n` high for exactly PULSE_CYC cycles. During the pulse, `tgt_dout_en` is 1, `tgt_vpp_en` is 1, and `tgt_addr` and `tgt_dout` do not change.
- R3: Before any pulse to a location, the target byte is read. If a bit that the source wants at 1 reads 0, the run stops with `err_code`=1 at that location, and no pulse is applied there.
- R4: A location that already reads equal to its source byte receives zero pulses.
- R5: After every pulse the location is read back and compared. Pulsing stops at the first match, so each location receives exactly the number of pulses the target needs.
- R6: If MAX_PULSES pulses have been applied to a location and it still mismatches, the run stops with `err_code`=2 and `err_addr` set to that location.
- R7: Locations are programmed in ascending order from 0 to 2^ADDR_W-1. After a run with no error, every target byte equals its source byte.
- R8: After the last location, a verify pass reads every location with `tgt_vpp_en`=0 and `tgt_vfy_sel`=1, and applies no pulses. A mismatch stops the run with `err_code`=3 and the failing location.
- R9: `tgt_dout_en` is never 1 while `tgt_oe_n` is 0. `tgt_oe_n` never falls in the cycle directly after a cycle with `tgt_dout_en`=1.
- R10: `busy` is high from the cycle after `start` until the end of the run. `done` is a single-cycle pulse at the end of the run. `err_code` and `err_addr` then hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run when idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err_code | output | 2 | 0 ok, 1 not erased, 2 pulse limit, 3 final verify mismatch |
| err_addr | output | ADDR_W | Location of the failure |
| src_addr | output | ADDR_W | Source read address |
| src_data | input | DATA_W | Source byte, one cycle after address |
| tgt_addr | output | ADDR_W | Target address |
| tgt_dout | output | DATA_W | Byte driven to the target |
| tgt_dout_en | output | 1 | Data-line drive enable |
| tgt_din | input | DATA_W | Byte read from the target |
| tgt_ce_n | output | 1 | Target chip enable / program strobe, active low |
| tgt_oe_n | output | 1 | Target output enable, active low |
| tgt_vpp_en | output | 1 | Program voltage enable flag |
| tgt_vfy_sel | output | 1 | Final verify supply-level select |

## Verification
A wrong pulse-timer count shows as a chip-enable low phase of the wrong length, visible at the very first pulse of a run. A retry counter that is wrong shows once the first location that needs several pulses finishes: it reports too many or too few pulses, or the limit error appears at the wrong point. An address or phase error shows up at the end of the run, either as a target image that differs from the source or as the wrong error code and location. The bench uses a target model that needs a set number of pulses per location, and that can return a marginal bit during the final pass, so that each of these faults reaches the ports.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SRC0,
    ST_SRC1,
    ST_BLANK,
    ST_SETUP,
    ST_DRIVE,
    ST_PULSE,
    ST_HOLD,
    ST_TURN,
    ST_VFY,
    ST_FREAD
  } seq_state_e;

  typedef enum logic [1:0] {
    ERR_NONE      = 2'd0,
    ERR_NOT_BLANK = 2'd1,
    ERR_LIMIT     = 2'd2,
    ERR_FINAL     = 2'd3
  } seq_err_e;

endpackage

// File: rtl/otp_pulse_timer.sv
module otp_pulse_timer #(
  parameter int PULSE_CYC = 10000
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic run,
  output logic last
);
  localparam int CW = $clog2(PULSE_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (go) begin
      run <= 1'b1;
      cnt <= CW'(PULSE_CYC - 1);
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - CW'(1);
    end
  end

  assign last = run && (cnt == '0);

  // R2: a new pulse is only started when the previous one has ended
  assert_timer_idle_on_go_R2: assert property (@(posedge clk) disable iff (rst)
    go |-> !run);

endmodule

// File: rtl/otp_try_cnt.sv
module otp_try_cnt #(
  parameter int MAX_PULSES = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic at_max
);
  localparam int TW = $clog2(MAX_PULSES + 1);

  logic [TW-1:0] count;

  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (inc)   count <= count + TW'(1);
  end

  assign at_max = (count == TW'(MAX_PULSES));

  // R6: never more than MAX_PULSES pulses at one location
  assert_try_limit_R6: assert property (@(posedge clk) disable iff (rst)
    inc |-> (count < TW'(MAX_PULSES)));

endmodule

// File: rtl/otp_byte_cmp.sv
module otp_byte_cmp #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] want,
  input  logic [DATA_W-1:0] got,
  output logic              match,
  output logic              blank_ok
);
  assign match    = (want == got);
  assign blank_ok = ((want & ~got) == '0);
endmodule

// File: rtl/otp_burn_seq.sv
module otp_burn_seq
  import otp_seq_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int PULSE_CYC  = 10000,
  parameter int MAX_PULSES = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [1:0]        err_code,
  output logic [ADDR_W-1:0] err_addr,
  output logic [ADDR_W-1:0] src_addr,
  input  logic [DATA_W-1:0] src_data,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [DATA_W-1:0] tgt_dout,
  output logic              tgt_dout_en,
  input  logic [DATA_W-1:0] tgt_din,
  output logic              tgt_ce_n,
  output logic              tgt_oe_n,
  output logic              tgt_vpp_en,
  output logic              tgt_vfy_sel
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};
  localparam int PW_W = $clog2(PULSE_CYC + 2);

  seq_state_e        state;
  seq_err_e          err_q, fcode;
  logic [ADDR_W-1:0] addr, err_addr_q;
  logic [DATA_W-1:0] want;
  logic              rd_wait, final_q;
  logic              ce_n_q, oe_n_q, den_q, vpp_q, vfy_q, busy_q, done_q;
  logic              t_go, t_run, t_last, try_clr, at_max;
  logic              match, blank_ok;
  logic              adv, fail, repulse;

  assign t_go    = (state == ST_DRIVE);
  assign try_clr = (state == ST_SRC1);

  otp_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
    .clk(clk), .rst(rst), .go(t_go), .run(t_run), .last(t_last)
  );

  otp_try_cnt #(.MAX_PULSES(MAX_PULSES)) u_tries (
    .clk(clk), .rst(rst), .clr(try_clr), .inc(t_go), .at_max(at_max)
  );

  otp_byte_cmp #(.DATA_W(DATA_W)) u_cmp (
    .want(want), .got(tgt_din), .match(match), .blank_ok(blank_ok)
  );

  // Decision at the second cycle of every target read
  always_comb begin
    adv     = 1'b0;
    fail    = 1'b0;
    repulse = 1'b0;
    fcode   = ERR_NONE;
    if (rd_wait) begin
      case (state)
        ST_BLANK: begin
          if (!blank_ok) begin fail = 1'b1; fcode = ERR_NOT_BLANK; end
          else if (match) adv = 1'b1;
          else            repulse = 1'b1;
        end
        ST_VFY: begin
          if (match)       adv = 1'b1;
          else if (at_max) begin fail = 1'b1; fcode = ERR_LIMIT; end
          else             repulse = 1'b1;
        end
        ST_FREAD: begin
          if (match) adv = 1'b1;
          else begin fail = 1'b1; fcode = ERR_FINAL; end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      addr       <= '0;
      want       <= '0;
      rd_wait    <= 1'b0;
      final_q    <= 1'b0;
      ce_n_q     <= 1'b1;
      oe_n_q     <= 1'b1;
      den_q      <= 1'b0;
      vpp_q      <= 1'b0;
      vfy_q      <= 1'b0;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= ERR_NONE;
      err_addr_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (fail) begin
        state      <= ST_IDLE;
        err_q      <= fcode;
        err_addr_q <= addr;
        busy_q     <= 1'b0;
        done_q     <= 1'b1;
        ce_n_q     <= 1'b1;
        oe_n_q     <= 1'b1;
        den_q      <= 1'b0;
        vpp_q      <= 1'b0;
        vfy_q      <= 1'b0;
        final_q    <= 1'b0;
        rd_wait    <= 1'b0;
      end else if (adv) begin
        ce_n_q  <= 1'b1;
        oe_n_q  <= 1'b1;
        rd_wait <= 1'b0;
        if (addr == LAST_ADDR) begin
          if (final_q) begin
            state   <= ST_IDLE;
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
            vfy_q   <= 1'b0;
            final_q <= 1'b0;
          end else begin
            final_q <= 1'b1;
            vpp_q   <= 1'b0;
            vfy_q   <= 1'b1;
            addr    <= '0;
            state   <= ST_SRC0;
          end
        end else begin
          addr  <= addr + ADDR_W'(1);
          state <= ST_SRC0;
        end
      end else if (repulse) begin
        ce_n_q  <= 1'b1;
        oe_n_q  <= 1'b1;
        rd_wait <= 1'b0;
        state   <= ST_SETUP;
      end else begin
        case (state)
          ST_IDLE: begin
            if (start) begin
              busy_q     <= 1'b1;
              err_q      <= ERR_NONE;
              err_addr_q <= '0;
              addr       <= '0;
              final_q    <= 1'b0;
              vpp_q      <= 1'b1;
              vfy_q      <= 1'b0;
              state      <= ST_SRC0;
            end
          end
          ST_SRC0: state <= ST_SRC1;
          ST_SRC1: begin
            want    <= src_data;
            ce_n_q  <= 1'b0;
            oe_n_q  <= 1'b0;
            rd_wait <= 1'b0;
            state   <= final_q ? ST_FREAD : ST_BLANK;
          end
          ST_BLANK, ST_VFY, ST_FREAD: rd_wait <= 1'b1;
          ST_SETUP: begin
            den_q <= 1'b1;
            state <= ST_DRIVE;
          end
          ST_DRIVE: begin
            ce_n_q <= 1'b0;
            state  <= ST_PULSE;
          end
          ST_PULSE: begin
            if (t_last) begin
              ce_n_q <= 1'b1;
              state  <= ST_HOLD;
            end
          end
          ST_HOLD: begin
            den_q <= 1'b0;
            state <= ST_TURN;
          end
          ST_TURN: begin
            ce_n_q <= 1'b0;
            oe_n_q <= 1'b0;
            state  <= ST_VFY;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy        = busy_q;
  assign done        = done_q;
  assign err_code    = err_q;
  assign err_addr    = err_addr_q;
  assign src_addr    = addr;
  assign tgt_addr    = addr;
  assign tgt_dout    = want;
  assign tgt_dout_en = den_q;
  assign tgt_ce_n    = ce_n_q;
  assign tgt_oe_n    = oe_n_q;
  assign tgt_vpp_en  = vpp_q;
  assign tgt_vfy_sel = vfy_q;

  // Pulse length observer for the width check
  logic [PW_W-1:0] pw_cnt;
  always_ff @(posedge clk) begin
    if (rst)                       pw_cnt <= '0;
    else if (!ce_n_q && oe_n_q)    pw_cnt <= pw_cnt + PW_W'(1);
    else                           pw_cnt <= '0;
  end

  assert_pulse_width_R2: assert property (@(posedge clk) disable iff (rst)
    ($rose(tgt_ce_n) && $past(tgt_oe_n)) |-> (pw_cnt == PW_W'(PULSE_CYC)));

  assert_addr_stable_R2: assert property (@(posedge clk) disable iff (rst)
    (!tgt_ce_n && tgt_oe_n) |-> ($stable(tgt_addr) && $stable(tgt_dout) && tgt_dout_en));

  assert_no_contention_R9: assert property (@(posedge clk) disable iff (rst)
    !(tgt_dout_en && !tgt_oe_n));

  assert_turn_gap_R9: assert property (@(posedge clk) disable iff (rst)
    !tgt_oe_n |-> !$past(tgt_dout_en));

  assert_final_no_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    (!tgt_ce_n && tgt_oe_n) |-> (tgt_vpp_en && !tgt_vfy_sel));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: tb/test_otp_burn_seq.sv
module test_otp_burn_seq;
  localparam int AW    = 4;
  localparam int DW    = 8;
  localparam int PULSE = 5;
  localparam int MAXP  = 4;
  localparam int NLOC  = 1 << AW;

  // {seed[8], need_mode[2], fault[2], fault_addr[4], exp_code[2], exp_addr[4]}
  // need_mode: 0 one pulse, 1 (a%3)+1, 2 MAXP each, 3 one except fault_addr MAXP+1
  // fault: 0 none, 1 not erased, 2 marginal bit in final pass, 3 pre-programmed
  localparam logic [21:0] VECS [0:7] = '{
    {8'h3C, 2'd0, 2'd0, 4'd0,  2'd0, 4'd0},
    {8'hA5, 2'd1, 2'd3, 4'd5,  2'd0, 4'd0},
    {8'h5A, 2'd2, 2'd0, 4'd0,  2'd0, 4'd0},
    {8'h11, 2'd3, 2'd0, 4'd6,  2'd2, 4'd6},
    {8'hC7, 2'd1, 2'd1, 4'd9,  2'd1, 4'd9},
    {8'h7E, 2'd0, 2'd2, 4'd12, 2'd3, 4'd12},
    {8'h00, 2'd0, 2'd3, 4'd15, 2'd0, 4'd0},
    {8'h99, 2'd0, 2'd1, 4'd0,  2'd1, 4'd0}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          busy, done;
  logic [1:0]    err_code;
  logic [AW-1:0] err_addr, src_addr, tgt_addr;
  logic [DW-1:0] src_q, tgt_dout, tgt_din;
  logic          tgt_dout_en, tgt_ce_n, tgt_oe_n, tgt_vpp_en, tgt_vfy_sel;

  logic [DW-1:0] smem [NLOC];
  logic [DW-1:0] tmem [NLOC];
  logic [DW-1:0] imem [NLOC];
  logic [DW-1:0] flip [NLOC];
  int            need [NLOC];
  int            pulses [NLOC];

  int n_chk = 0, n_fail = 0;
  int plen = 0, bad_width = 0, bad_addr = 0, bad_prog = 0, bad_bus = 0;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] pdat = '0;
  logic prev_den = 1'b0, saw_vfy = 1'b0;

  always #5 clk = ~clk;

  always @(posedge clk) src_q <= smem[src_addr];

  assign tgt_din = (!tgt_ce_n && !tgt_oe_n)
                 ? (tmem[tgt_addr] ^ (tgt_vfy_sel ? flip[tgt_addr] : '0)) : 8'hFF;

  otp_burn_seq #(.ADDR_W(AW), .DATA_W(DW), .PULSE_CYC(PULSE), .MAX_PULSES(MAXP)) i_otp_burn_seq (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .err_code(err_code), .err_addr(err_addr), .src_addr(src_addr), .src_data(src_q),
    .tgt_addr(tgt_addr), .tgt_dout(tgt_dout), .tgt_dout_en(tgt_dout_en), .tgt_din(tgt_din),
    .tgt_ce_n(tgt_ce_n), .tgt_oe_n(tgt_oe_n), .tgt_vpp_en(tgt_vpp_en), .tgt_vfy_sel(tgt_vfy_sel)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Target model and bus monitor, advanced once per cycle away from the active edge
  task automatic cyc();
    @(negedge clk);
    if (!tgt_ce_n && tgt_oe_n) begin
      if (plen == 0) begin paddr = tgt_addr; pdat = tgt_dout; end
      else if (tgt_addr != paddr || tgt_dout != pdat) bad_addr++;
      if (!tgt_dout_en || !tgt_vpp_en || tgt_vfy_sel) bad_prog++;
      plen++;
    end else if (plen != 0) begin
      if (plen != PULSE) bad_width++;
      pulses[paddr]++;
      if (pulses[paddr] >= need[paddr]) tmem[paddr] = tmem[paddr] & pdat;
      plen = 0;
    end
    if (tgt_dout_en && !tgt_oe_n) bad_bus++;
    if (!tgt_oe_n && prev_den) bad_bus++;
    prev_den = tgt_dout_en;
    if (tgt_vfy_sel) saw_vfy = 1'b1;
  endtask

  task automatic check_idle(input string tag);
    check(tgt_ce_n == 1'b1 && tgt_oe_n == 1'b1, "R1", {tag, " strobes"}, {tgt_ce_n, tgt_oe_n}, 3);
    check(tgt_dout_en == 1'b0 && tgt_vpp_en == 1'b0 && tgt_vfy_sel == 1'b0, "R1", {tag, " drive/vpp/vfy"},
          {tgt_dout_en, tgt_vpp_en, tgt_vfy_sel}, 0);
    check(busy == 1'b0 && done == 1'b0 && err_code == 2'd0, "R1", {tag, " busy/done/err"},
          {busy, done, err_code}, 0);
  endtask

  task automatic setup(input logic [21:0] v);
    logic [7:0] seed;
    logic [1:0] nm, ft;
    logic [3:0] fa;
    seed = v[21:14]; nm = v[13:12]; ft = v[11:10]; fa = v[9:6];
    for (int a = 0; a < NLOC; a++) begin
      smem[a]   = seed ^ (8'(a) * 8'd29 + 8'd7);
      tmem[a]   = 8'hFF;
      flip[a]   = 8'h00;
      pulses[a] = 0;
      case (nm)
        2'd1:    need[a] = (a % 3) + 1;
        2'd2:    need[a] = MAXP;
        default: need[a] = 1;
      endcase
    end
    if (nm == 2'd3) need[fa] = MAXP + 1;
    case (ft)
      2'd1: begin smem[fa] = 8'hF0; tmem[fa] = 8'h7F; end
      2'd2: flip[fa] = 8'h10;
      2'd3: tmem[fa] = smem[fa];
      default: ;
    endcase
    for (int a = 0; a < NLOC; a++) imem[a] = tmem[a];
    bad_width = 0; bad_addr = 0; bad_prog = 0; bad_bus = 0; saw_vfy = 1'b0; plen = 0;
  endtask

  task automatic run_vec(input int idx, input logic [21:0] v);
    logic [1:0] ft, ec;
    logic [3:0] fa, ea;
    int lim, got_done, mem_bad, pl_bad, busy_bad;
    logic [1:0] code0;
    ft = v[11:10]; fa = v[9:6]; ec = v[5:4]; ea = v[3:0];
    setup(v);
    start = 1'b1;
    cyc();
    start = 1'b0;
    got_done = 0; busy_bad = 0;
    for (int i = 0; i < 20000; i++) begin
      cyc();
      if (done) begin got_done = 1; break; end
      if (!busy) busy_bad++;
    end
    check(got_done == 1, "R10", $sformatf("vec%0d done pulse", idx), got_done, 1);
    check(busy_bad == 0, "R10", $sformatf("vec%0d busy during run", idx), busy_bad, 0);
    check(err_code == ec, ec == 2'd1 ? "R3" : ec == 2'd2 ? "R6" : ec == 2'd3 ? "R8" : "R7",
          $sformatf("vec%0d err_code", idx), err_code, ec);
    if (ec != 2'd0)
      check(err_addr == ea, ec == 2'd1 ? "R3" : ec == 2'd2 ? "R6" : "R8",
            $sformatf("vec%0d err_addr", idx), err_addr, ea);
    lim = (ec == 2'd0 || ec == 2'd3) ? NLOC : int'(ea);
    mem_bad = 0; pl_bad = 0;
    for (int a = 0; a < lim; a++) begin
      if (tmem[a] != smem[a]) mem_bad++;
      if (pulses[a] != ((imem[a] == smem[a]) ? 0 : need[a])) pl_bad++;
    end
    check(mem_bad == 0, "R7", $sformatf("vec%0d image mismatches", idx), mem_bad, 0);
    check(pl_bad == 0, "R5", $sformatf("vec%0d pulse-count mismatches", idx), pl_bad, 0);
    if (ec == 2'd1) check(pulses[ea] == 0, "R3", $sformatf("vec%0d pulses at non-erased loc", idx), pulses[ea], 0);
    if (ec == 2'd2) check(pulses[ea] == MAXP, "R6", $sformatf("vec%0d pulses at limit loc", idx), pulses[ea], MAXP);
    if (ft == 2'd3) check(pulses[fa] == 0, "R4", $sformatf("vec%0d pulses at matching loc", idx), pulses[fa], 0);
    if (ec == 2'd0 || ec == 2'd3)
      check(saw_vfy == 1'b1, "R8", $sformatf("vec%0d verify select seen", idx), saw_vfy, 1);
    check(bad_width == 0 && bad_addr == 0, "R2", $sformatf("vec%0d pulse shape errors", idx),
          bad_width + bad_addr, 0);
    check(bad_prog == 0, "R8", $sformatf("vec%0d pulses outside program phase", idx), bad_prog, 0);
    check(bad_bus == 0, "R9", $sformatf("vec%0d bus turnaround errors", idx), bad_bus, 0);
    code0 = err_code;
    for (int i = 0; i < 4; i++) cyc();
    check(err_code == code0 && !busy && !done && !tgt_vpp_en && !tgt_vfy_sel, "R10",
          $sformatf("vec%0d idle hold after end", idx), {err_code, busy, done}, {code0, 2'b00});
  endtask

  initial begin
    for (int a = 0; a < NLOC; a++) begin
      smem[a] = '0; tmem[a] = 8'hFF; imem[a] = 8'hFF; flip[a] = '0; need[a] = 1; pulses[a] = 0;
    end
    repeat (3) cyc();
    check_idle("in reset");
    rst = 1'b0;
    repeat (3) cyc();
    check_idle("after reset");

    for (int k = 0; k < 8; k++) run_vec(k, VECS[k]);

    // Reset in the middle of a run returns every output to idle
    setup(VECS[2]);
    start = 1'b1;
    cyc();
    start = 1'b0;
    repeat (40) cyc();
    check(busy == 1'b1, "R10", "busy mid-run", busy, 1);
    rst = 1'b1;
    repeat (2) cyc();
    check_idle("mid-run reset");
    rst = 1'b0;
    repeat (2) cyc();

    // After the reset a fresh run still completes cleanly
    run_vec(8, VECS[0]);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

endmodule